// File: doc/BRIEF.md
# Buck Converter Soft-Start and Input Lockout Sequencer

This block sits between a step-down converter's enable pin and its power stage. It tracks whether the input supply is usable, using two comparator flags with separated thresholds. One flag says the supply has crossed the upper level, near 2.9 V. The other says it has dropped under the lower level, near 2.7 V. The result is a lockout status that does not chatter. While the supply is not usable, the converter is held off and its low-side switch is asked to discharge the output.

A start-up ramp is armed only by a low-to-high transition of the enable pin seen while the supply is already valid. Once armed, the switch current-limit selection climbs through four fixed levels: 250 mA, 500 mA, 950 mA and 2 A. Each of the three lower levels lasts a programmable number of step ticks. The limit then stays at 2 A and a done flag is raised. Dropping the enable or losing the supply at any point returns the block to shutdown at the lowest limit. The analog comparators and the current comparator are outside this block.

Top module: `buck_start_seq`

## Requirements
- R1: The supply-good status rises one clock after the upper-threshold flag is sampled high while the lower-threshold flag is low.
- R2: The supply-good status falls one clock after the lower-threshold flag is sampled high, and this holds even when both flags are high. When neither flag is high the status keeps its value.
- R3: While supply-good is low, the converter enable output is low, whatever the enable pin does.
- R4: A ramp starts only when the enable pin is sampled high on a clock where it was low on the previous clock and supply-good is high. The converter enable output is high from the clock after that edge.
- R5: An enable pin that is already high when supply-good rises does not start a ramp. The pin must go low and then high again.
- R6: The current-limit code encodes 0 = 250 mA, 1 = 500 mA, 2 = 950 mA and 3 = 2 A. A ramp begins at code 0. Codes 0, 1 and 2 each step up on the STEP_TICKS-th step tick received at that code.
- R7: After code 3 is reached, the done flag is high and code 3 holds for as long as the enable pin and supply-good stay high.
- R8: Enable pin low during a ramp or after it drops the converter enable output in the same cycle. The code returns to 0 and the done flag to low one clock later. Supply-good low aborts the same way, one clock after supply-good falls.
- R9: The discharge request equals the inverse of the converter enable output at all times.
- R10: After reset, supply-good, converter enable, done and the code are all 0, and the discharge request is 1.
- R11: Step ticks have no effect while the converter is shut down or after the ramp has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vin_above_hi | input | 1 | Supply is above the upper lockout threshold |
| vin_below_lo | input | 1 | Supply is below the lower lockout threshold |
| en_pin | input | 1 | Converter enable pin |
| step_tick | input | 1 | One-cycle pulse that paces the current-limit steps |
| vin_ok | output | 1 | Supply-good status with hysteresis |
| conv_en | output | 1 | Effective converter enable |
| ilim_code | output | 2 | Current-limit selection, 0..3 = 250 mA, 500 mA, 950 mA, 2 A |
| ss_done | output | 1 | Ramp has reached the final limit |
| ls_discharge | output | 1 | Low-side discharge request during shutdown |

## Verification
A wrong lockout state appears one clock after a threshold flag changes, as an enable that ignores or obeys the pin at the wrong time. A stuck or mis-armed edge detector shows on the first enable toggle as a ramp that starts when it should not, or fails to start. A miscounting tick counter moves the code one tick early or late, and this is caught at every step boundary of the ramp. A state that fails to abort leaves a non-zero code or a raised done flag one clock after the enable or the supply is withdrawn.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_RAMP = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    // Order is behaviour: the ramp walks these upward.
    typedef enum logic [1:0] {
        ILIM_250  = 2'd0,
        ILIM_500  = 2'd1,
        ILIM_950  = 2'd2,
        ILIM_2000 = 2'd3
    } ilim_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } vin_flags_t;

    typedef struct packed {
        seq_state_e state;
        ilim_e      level;
    } ramp_status_t;

    function automatic ilim_e ilim_next(ilim_e cur);
        if (cur == ILIM_2000) return ILIM_2000;
        return ilim_e'(cur + 2'd1);
    endfunction

    function automatic logic ilim_is_top(ilim_e cur);
        return cur == ILIM_2000;
    endfunction

endpackage

// File: rtl/bss_uvlo.sv
module bss_uvlo
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  vin_flags_t flags,
    output logic       vin_ok
);

    always_ff @(posedge clk) begin
        if (rst)
            vin_ok <= 1'b0;
        else if (flags.lo)
            vin_ok <= 1'b0;
        else if (flags.hi)
            vin_ok <= 1'b1;
    end

    AST_UVLO_SET: assert property (@(posedge clk) disable iff (rst)
        (flags.hi && !flags.lo) |=> vin_ok);                 // R1
    AST_UVLO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flags.lo |=> !vin_ok);                                // R2
    AST_UVLO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flags.hi && !flags.lo) |=> $stable(vin_ok));        // R2

endmodule

// File: rtl/bss_arm.sv
module bss_arm (
    input  logic clk,
    input  logic rst,
    input  logic en_pin,
    input  logic vin_ok,
    output logic start
);

    logic en_prev;

    // Reset to 1 so that a pin held high through reset must toggle first.
    always_ff @(posedge clk) begin
        if (rst)
            en_prev <= 1'b1;
        else
            en_prev <= en_pin;
    end

    assign start = en_pin && !en_prev && vin_ok;

    AST_NO_START_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        !vin_ok |-> !start);                                  // R3
    AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(!en_pin));                            // R5

endmodule

// File: rtl/bss_ramp.sv
module bss_ramp
    import bss_pkg::*;
#(
    parameter int STEP_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         vin_ok,
    input  logic         en_pin,
    input  logic         step_tick,
    output ramp_status_t status
);

    localparam int STEPS_SAFE = (STEP_TICKS < 1) ? 1 : STEP_TICKS;
    localparam int CW         = (STEPS_SAFE > 1) ? $clog2(STEPS_SAFE) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STEPS_SAFE - 1);

    seq_state_e    state;
    ilim_e         level;
    logic [CW-1:0] tick_cnt;
    logic          keep;

    assign keep = vin_ok && en_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_OFF;
            level    <= ILIM_250;
            tick_cnt <= '0;
        end else begin
            unique case (state)
                SEQ_OFF: begin
                    level    <= ILIM_250;
                    tick_cnt <= '0;
                    if (start) state <= SEQ_RAMP;
                end
                SEQ_RAMP: begin
                    if (!keep) begin
                        state    <= SEQ_OFF;
                        level    <= ILIM_250;
                        tick_cnt <= '0;
                    end else if (step_tick) begin
                        if (tick_cnt == LAST_CNT) begin
                            tick_cnt <= '0;
                            level    <= ilim_next(level);
                            if (ilim_is_top(ilim_next(level))) state <= SEQ_RUN;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (!keep) begin
                        state    <= SEQ_OFF;
                        level    <= ILIM_250;
                        tick_cnt <= '0;
                    end
                end
                default: begin
                    state    <= SEQ_OFF;
                    level    <= ILIM_250;
                    tick_cnt <= '0;
                end
            endcase
        end
    end

    assign status.state = state;
    assign status.level = level;

    AST_STAY_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_OFF && !start) |=> state == SEQ_OFF);   // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RAMP && keep && !step_tick) |=> level == $past(level)); // R6
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_OFF && keep) |=>
            (level == $past(level) || level == ilim_e'($past(level) + 2'd1))); // R6
    AST_RUN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        state == SEQ_RUN |-> level == ILIM_2000);             // R7
    AST_ABORT_RESETS: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_OFF && !keep) |=> (state == SEQ_OFF && level == ILIM_250)); // R8
    AST_OFF_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_OFF) |-> level == ILIM_250);            // R11

endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
    import bss_pkg::*;
#(
    parameter int STEP_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vin_above_hi,
    input  logic       vin_below_lo,
    input  logic       en_pin,
    input  logic       step_tick,
    output logic       vin_ok,
    output logic       conv_en,
    output logic [1:0] ilim_code,
    output logic       ss_done,
    output logic       ls_discharge
);

    vin_flags_t   flags;
    logic         start;
    ramp_status_t rs;

    assign flags.hi = vin_above_hi;
    assign flags.lo = vin_below_lo;

    bss_uvlo u_uvlo (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .vin_ok (vin_ok)
    );

    bss_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .en_pin (en_pin),
        .vin_ok (vin_ok),
        .start  (start)
    );

    bss_ramp #(.STEP_TICKS(STEP_TICKS)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vin_ok    (vin_ok),
        .en_pin    (en_pin),
        .step_tick (step_tick),
        .status    (rs)
    );

    assign conv_en      = (rs.state != SEQ_OFF) && vin_ok && en_pin;
    assign ls_discharge = !conv_en;
    assign ilim_code    = rs.level;
    assign ss_done      = (rs.state == SEQ_RUN);

    AST_LOCKOUT_GATES: assert property (@(posedge clk) disable iff (rst)
        !vin_ok |-> (!conv_en && ls_discharge));              // R3
    AST_DONE_TOP_CODE: assert property (@(posedge clk) disable iff (rst)
        ss_done |-> ilim_code == 2'd3);                       // R7
    AST_DISCHARGE_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
        $countones({conv_en, ls_discharge}) == 1);            // R9

endmodule

// File: tb/buck_start_seq_tb.sv
module buck_start_seq_tb;

    localparam int TICKS = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       vin_above_hi, vin_below_lo, en_pin, step_tick;
    logic       vin_ok, conv_en, ss_done, ls_discharge;
    logic [1:0] ilim_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    buck_start_seq #(.STEP_TICKS(TICKS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .vin_above_hi (vin_above_hi),
        .vin_below_lo (vin_below_lo),
        .en_pin       (en_pin),
        .step_tick    (step_tick),
        .vin_ok       (vin_ok),
        .conv_en      (conv_en),
        .ilim_code    (ilim_code),
        .ss_done      (ss_done),
        .ls_discharge (ls_discharge)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance n clocks; inputs and checks happen at falling edges.
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse();
        step_tick = 1'b1;
        cyc(1);
        step_tick = 1'b0;
    endtask

    task automatic make_vin_ok();
        vin_above_hi = 1'b1; vin_below_lo = 1'b0;
        cyc(1);
        vin_above_hi = 1'b0;
    endtask

    task automatic drop_vin();
        vin_below_lo = 1'b1; vin_above_hi = 1'b0;
        cyc(1);
        vin_below_lo = 1'b0;
    endtask

    task automatic enable_edge();
        en_pin = 1'b0;
        cyc(1);
        en_pin = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        vin_above_hi = 1'b0; vin_below_lo = 1'b0; en_pin = 1'b0; step_tick = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R10", "vin_ok", vin_ok, 0);
        chk("R10", "conv_en", conv_en, 0);
        chk("R10", "ilim_code", ilim_code, 0);
        chk("R10", "ss_done", ss_done, 0);
        chk("R10", "ls_discharge", ls_discharge, 1);
    endtask

    task automatic t_uvlo();
        make_vin_ok();
        chk("R1", "vin_ok after upper flag", vin_ok, 1);
        cyc(3);
        chk("R2", "vin_ok held with no flags", vin_ok, 1);
        vin_above_hi = 1'b1; vin_below_lo = 1'b1;
        cyc(1);
        vin_above_hi = 1'b0; vin_below_lo = 1'b0;
        chk("R2", "lower flag wins over upper", vin_ok, 0);
        cyc(3);
        chk("R2", "vin_ok stays low with no flags", vin_ok, 0);
        make_vin_ok();
        chk("R1", "vin_ok set again", vin_ok, 1);
        drop_vin();
        chk("R2", "vin_ok cleared by lower flag", vin_ok, 0);
    endtask

    task automatic t_lockout_and_arm();
        en_pin = 1'b1;
        cyc(2);
        chk("R3", "conv_en while locked out", conv_en, 0);
        chk("R9", "discharge while locked out", ls_discharge, 1);
        make_vin_ok();
        cyc(2);
        chk("R5", "pin high before supply does not start", conv_en, 0);
        chk("R5", "code stays lowest", ilim_code, 0);
        enable_edge();
        chk("R4", "conv_en after fresh edge", conv_en, 1);
        chk("R9", "discharge off while running", ls_discharge, 0);
        chk("R6", "ramp begins at code 0", ilim_code, 0);
    endtask

    task automatic t_ramp_full();
        for (int lvl = 0; lvl < 3; lvl++) begin
            for (int t = 0; t < TICKS - 1; t++) begin
                tick_pulse();
                cyc(1);
            end
            chk("R6", "code held before last tick", ilim_code, lvl);
            chk("R7", "done low during ramp", ss_done, 0);
            tick_pulse();
            chk("R6", "code after last tick", ilim_code, lvl + 1);
        end
        chk("R7", "done at top", ss_done, 1);
        for (int t = 0; t < 6; t++) tick_pulse();
        chk("R11", "ticks after ramp keep code", ilim_code, 3);
        chk("R7", "done held", ss_done, 1);
    endtask

    task automatic t_abort_en();
        en_pin = 1'b0;
        #1;
        chk("R8", "conv_en drops with pin", conv_en, 0);
        cyc(1);
        chk("R8", "code back to lowest", ilim_code, 0);
        chk("R8", "done cleared", ss_done, 0);
        for (int t = 0; t < 6; t++) tick_pulse();
        chk("R11", "ticks while off ignored", ilim_code, 0);
        enable_edge();
        chk("R4", "restart after edge", conv_en, 1);
        tick_pulse();
        chk("R6", "single tick holds code 0", ilim_code, 0);
    endtask

    task automatic t_abort_vin();
        for (int t = 0; t < TICKS; t++) tick_pulse();
        chk("R6", "mid-ramp code 1", ilim_code, 1);
        drop_vin();
        chk("R8", "conv_en off after supply loss", conv_en, 0);
        cyc(1);
        chk("R8", "code lowest after supply loss", ilim_code, 0);
        make_vin_ok();
        cyc(1);
        chk("R5", "no restart with pin still high", conv_en, 0);
        enable_edge();
        chk("R4", "restart with new edge", conv_en, 1);
        for (int t = 0; t < 3 * TICKS; t++) tick_pulse();
        chk("R7", "done after full ramp", ss_done, 1);
        drop_vin();
        cyc(1);
        chk("R8", "done cleared after supply loss", ss_done, 0);
        chk("R9", "discharge on after supply loss", ls_discharge, 1);
    endtask

    initial begin
        t_reset();
        t_uvlo();
        t_lockout_and_arm();
        t_ramp_full();
        t_abort_en();
        t_abort_vin();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule